// File: doc/BRIEF.md
# Pre-Commit Protection Fault Checker

This block inspects one memory or control-register operation per request and decides, before it is allowed to commit, whether it must raise a general-protection fault. Three checks run side by side. The canonical-form check covers the linear address in 64-bit mode. The 16-byte alignment check covers 128-bit vector and stack accesses. The reserved-bit check covers writes to the vector control/status register. A fixed priority folds the three results into a single fault decision with one cause.

The result is registered one cycle after the request. The block returns a fault strobe, a cause code, a 16-bit error code and the instruction pointer of the faulting operation, or a commit strobe when no check fails. The block holds the vector control/status register itself. This register is written only by a committed, fault-free write, so a faulting operation leaves it unchanged and the instruction can be restarted.

Top module: `gpf_guard`

## Requirements
- R1: A control/status write (op 3) whose write data has any bit set where the reserved mask is 1 faults with cause 1. The held register `csr_o` keeps its old value.
- R2: A control/status write with no reserved bit set commits. On the same edge `csr_o` takes the write data.
- R3: Vector (op 1) and stack (op 2) accesses fault with cause 3 when address bits [3:0] are not all zero. Plain accesses (op 0) are never checked for alignment.
- R4: When `mode64_i` is 1, any operation whose address bits 63 down to 47 are not all equal faults with cause 2. This includes the memory operand of a control/status write.
- R5: When `mode64_i` is 0, the canonical check is skipped. The alignment and reserved-bit checks still apply.
- R6: When several checks fail, only one cause is reported. Reserved-bit (1) wins over non-canonical (2), which wins over misalignment (3). Cause 0 means no fault.
- R7: On a fault with `desc_ld_i` set, `err_o` equals `sel_i`. In every other case, including a fault without a descriptor load, `err_o` is 0.
- R8: `commit_o` pulses exactly one cycle after a valid request that raises no fault. `commit_o` and `fault_o` are never high together.
- R9: On a fault, `fault_ip_o` equals the `ip_i` of the faulting request, not the next address. When there is no fault it is 0.
- R10: After reset every output is 0 except `csr_o`, which holds the parameter `CSR_RST`.
- R11: A cycle without `req_i` produces no fault and no commit, and it leaves `csr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request valid |
| op_i | input | 2 | Operation: 0 plain, 1 vector 128-bit, 2 stack, 3 control/status write |
| addr_i | input | 64 | Linear address |
| mode64_i | input | 1 | 64-bit mode active |
| wdata_i | input | 32 | Control/status write data |
| rsvd_mask_i | input | 32 | Reserved-bit mask, 1 marks a reserved bit |
| desc_ld_i | input | 1 | Check happens during a segment descriptor load |
| sel_i | input | 16 | Selector or vector number of that descriptor |
| ip_i | input | 64 | Address of the requesting instruction |
| fault_o | output | 1 | Fault strobe |
| kind_o | output | 2 | Fault cause code |
| err_o | output | 16 | Error code |
| fault_ip_o | output | 64 | Saved instruction pointer of the fault |
| commit_o | output | 1 | Commit strobe |
| csr_o | output | 32 | Current control/status register value |

## Verification
The hardest case to reach is a single request that trips all three checks at once, because the alignment check never looks at control/status writes. The bench therefore builds the overlaps in pairs. A control/status write carries a reserved bit and a non-canonical operand address. A vector access in 64-bit mode carries both a non-canonical and a misaligned address. These pairs show the priority, and also show that the register stays untouched under the higher-priority cause. A fault without a descriptor load is driven with a nonzero selector, so the bench can confirm that the error code stays zero in that case.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN  = 2'd0,
        OP_VEC128 = 2'd1,
        OP_STACK  = 2'd2,
        OP_CSR_WR = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        FK_NONE     = 2'd0,
        FK_RSVD     = 2'd1,
        FK_NONCANON = 2'd2,
        FK_MISALIGN = 2'd3
    } fault_kind_e;

    typedef struct packed {
        logic rsvd;
        logic noncanon;
        logic misalign;
    } chk_flags_t;

    function automatic logic op_is_memory(op_kind_e op);
        return 1'b1;
    endfunction

    function automatic logic op_needs_align(op_kind_e op);
        return (op == OP_VEC128) || (op == OP_STACK);
    endfunction

    function automatic fault_kind_e pick_fault(chk_flags_t f);
        if (f.rsvd)          return FK_RSVD;
        else if (f.noncanon) return FK_NONCANON;
        else if (f.misalign) return FK_MISALIGN;
        else                 return FK_NONE;
    endfunction

endpackage

// File: rtl/gpf_canon_chk.sv
module gpf_canon_chk #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              enable,
    output logic              bad
);
    localparam int TOP_N = ADDR_W - VA_BITS + 1;
    localparam int SIGN  = VA_BITS - 1;

    logic [TOP_N-1:0] differ;

    for (genvar i = 0; i < TOP_N; i++) begin : g_bit
        assign differ[i] = addr[SIGN + i] ^ addr[SIGN];
    end

    assign bad = enable & (|differ);
endmodule

// File: rtl/gpf_align_chk.sv
module gpf_align_chk #(
    parameter int ADDR_W   = 64,
    parameter int ALIGN_LG = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              enable,
    output logic              bad
);
    assign bad = enable & (|addr[ALIGN_LG-1:0]);
endmodule

// File: rtl/gpf_rsvd_chk.sv
module gpf_rsvd_chk #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mask,
    input  logic              enable,
    output logic              bad
);
    logic [DATA_W-1:0] hit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign hit[i] = wdata[i] & mask[i];
    end

    assign bad = enable & (|hit);
endmodule

// File: rtl/gpf_guard.sv
module gpf_guard
    import gpf_pkg::*;
#(
    parameter int              ADDR_W   = 64,
    parameter int              VA_BITS  = 48,
    parameter int              ALIGN_LG = 4,
    parameter int              DATA_W   = 32,
    parameter int              SEL_W    = 16,
    parameter logic [DATA_W-1:0] CSR_RST = 32'h0000_1F80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mode64_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rsvd_mask_i,
    input  logic              desc_ld_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [ADDR_W-1:0] ip_i,
    output logic              fault_o,
    output logic [1:0]        kind_o,
    output logic [SEL_W-1:0]  err_o,
    output logic [ADDR_W-1:0] fault_ip_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] csr_o
);
    op_kind_e    op;
    chk_flags_t  flags;
    fault_kind_e kind_d;
    logic        fault_d;
    logic        commit_d;
    logic        csr_we;

    assign op = op_kind_e'(op_i);

    gpf_canon_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_canon (
        .addr   (addr_i),
        .enable (mode64_i & op_is_memory(op)),
        .bad    (flags.noncanon)
    );

    gpf_align_chk #(.ADDR_W(ADDR_W), .ALIGN_LG(ALIGN_LG)) u_align (
        .addr   (addr_i),
        .enable (op_needs_align(op)),
        .bad    (flags.misalign)
    );

    gpf_rsvd_chk #(.DATA_W(DATA_W)) u_rsvd (
        .wdata  (wdata_i),
        .mask   (rsvd_mask_i),
        .enable (op == OP_CSR_WR),
        .bad    (flags.rsvd)
    );

    always_comb begin
        kind_d   = pick_fault(flags);
        fault_d  = req_i && (kind_d != FK_NONE);
        commit_d = req_i && (kind_d == FK_NONE);
        csr_we   = commit_d && (op == OP_CSR_WR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_o    <= 1'b0;
            kind_o     <= FK_NONE;
            err_o      <= '0;
            fault_ip_o <= '0;
            commit_o   <= 1'b0;
            csr_o      <= CSR_RST;
        end else begin
            fault_o    <= fault_d;
            commit_o   <= commit_d;
            kind_o     <= fault_d ? kind_d : FK_NONE;
            err_o      <= (fault_d && desc_ld_i) ? sel_i : '0;
            fault_ip_o <= fault_d ? ip_i : '0;
            if (csr_we) csr_o <= wdata_i;
        end
    end
endmodule

// File: rtl/gpf_guard_chk.sv
module gpf_guard_chk #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic [1:0]        op_i,
    input logic              desc_ld_i,
    input logic              fault_o,
    input logic [1:0]        kind_o,
    input logic [SEL_W-1:0]  err_o,
    input logic [ADDR_W-1:0] fault_ip_o,
    input logic              commit_o,
    input logic [DATA_W-1:0] csr_o
);
    a_r8_commit_excl: assert property (@(posedge clk) disable iff (rst)
        !(fault_o && commit_o));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(req_i) |-> (!fault_o && !commit_o));

    a_r1_csr_hold_on_fault: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> $stable(csr_o));

    a_r6_cause_present: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (kind_o != 2'd0));

    a_r7_err_zero: assert property (@(posedge clk) disable iff (rst)
        (!fault_o || !$past(desc_ld_i)) |-> (err_o == '0));

    a_r9_ip_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !fault_o |-> (fault_ip_o == '0));

    a_r2_csr_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        !(commit_o && $past(op_i) == 2'd3) |-> $stable(csr_o));
endmodule

bind gpf_guard gpf_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .op_i       (op_i),
    .desc_ld_i  (desc_ld_i),
    .fault_o    (fault_o),
    .kind_o     (kind_o),
    .err_o      (err_o),
    .fault_ip_o (fault_ip_o),
    .commit_o   (commit_o),
    .csr_o      (csr_o)
);

// File: tb/tb_gpf_guard.sv
module tb_gpf_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_i;
    logic [1:0]  op_i;
    logic [63:0] addr_i;
    logic        mode64_i;
    logic [31:0] wdata_i;
    logic [31:0] rsvd_mask_i;
    logic        desc_ld_i;
    logic [15:0] sel_i;
    logic [63:0] ip_i;
    logic        fault_o;
    logic [1:0]  kind_o;
    logic [15:0] err_o;
    logic [63:0] fault_ip_o;
    logic        commit_o;
    logic [31:0] csr_o;

    int total = 0;
    int bad   = 0;

    localparam logic [63:0] CANON_LO  = 64'h0000_7FFF_FFFF_FFF0;
    localparam logic [63:0] CANON_HI  = 64'hFFFF_8000_0000_0000;
    localparam logic [63:0] NONCAN_A  = 64'h0000_8000_0000_0000;
    localparam logic [63:0] NONCAN_B  = 64'hFFFF_0000_0000_0000;
    localparam logic [31:0] MASK      = 32'hFFFF_0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpf_guard dut (
        .clk(clk), .rst(rst), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
        .mode64_i(mode64_i), .wdata_i(wdata_i), .rsvd_mask_i(rsvd_mask_i),
        .desc_ld_i(desc_ld_i), .sel_i(sel_i), .ip_i(ip_i),
        .fault_o(fault_o), .kind_o(kind_o), .err_o(err_o),
        .fault_ip_o(fault_ip_o), .commit_o(commit_o), .csr_o(csr_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_i = 0; op_i = 0; addr_i = 0; mode64_i = 1; wdata_i = 0;
        rsvd_mask_i = MASK; desc_ld_i = 0; sel_i = 0; ip_i = 0;
    endtask

    // drive one request on a falling edge, sample after the next rising edge
    task automatic issue(input logic [1:0] op, input logic [63:0] addr,
                         input logic m64, input logic [31:0] wd,
                         input logic dl, input logic [15:0] sel,
                         input logic [63:0] ip);
        @(negedge clk);
        req_i = 1; op_i = op; addr_i = addr; mode64_i = m64; wdata_i = wd;
        desc_ld_i = dl; sel_i = sel; ip_i = ip;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic expect_out(input string tag, input logic f, input logic [1:0] k,
                              input logic c);
        check(fault_o == f,  {tag, " fault"},  fault_o,  f);
        check(kind_o == k,   {tag, " kind"},   kind_o,   k);
        check(commit_o == c, {tag, " commit"}, commit_o, c);
    endtask

    task automatic t_reset();
        check(fault_o == 0 && commit_o == 0 && kind_o == 0 && err_o == 0 &&
              fault_ip_o == 0, "R10 outputs zero", {fault_o, commit_o, kind_o}, 0);
        check(csr_o == 32'h0000_1F80, "R10 csr reset", csr_o, 32'h0000_1F80);
    endtask

    task automatic t_csr_ok();
        issue(2'd3, CANON_LO, 1, 32'h0000_1234, 0, 0, 64'h100);
        expect_out("R2 csr write ok", 0, 0, 1);
        check(csr_o == 32'h0000_1234, "R2 csr updated", csr_o, 32'h0000_1234);
    endtask

    task automatic t_csr_rsvd();
        issue(2'd3, CANON_LO, 1, 32'h0001_5555, 0, 0, 64'h104);
        expect_out("R1 csr rsvd", 1, 1, 0);
        check(csr_o == 32'h0000_1234, "R1 csr kept", csr_o, 32'h0000_1234);
        check(fault_ip_o == 64'h104, "R9 saved ip", fault_ip_o, 64'h104);
    endtask

    task automatic t_align();
        issue(2'd1, 64'h1008, 1, 0, 0, 0, 64'h200);
        expect_out("R3 vec misaligned", 1, 3, 0);
        issue(2'd2, 64'h2004, 1, 0, 0, 0, 64'h204);
        expect_out("R3 stack misaligned", 1, 3, 0);
        issue(2'd1, 64'h1010, 1, 0, 0, 0, 64'h208);
        expect_out("R3 vec aligned", 0, 0, 1);
        issue(2'd0, 64'h1003, 1, 0, 0, 0, 64'h20C);
        expect_out("R3 plain unaligned ok", 0, 0, 1);
    endtask

    task automatic t_canon();
        issue(2'd0, NONCAN_A, 1, 0, 0, 0, 64'h300);
        expect_out("R4 noncanon bit47", 1, 2, 0);
        issue(2'd0, NONCAN_B, 1, 0, 0, 0, 64'h304);
        expect_out("R4 noncanon upper", 1, 2, 0);
        issue(2'd0, CANON_HI, 1, 0, 0, 0, 64'h308);
        expect_out("R4 canonical high", 0, 0, 1);
        issue(2'd0, CANON_LO, 1, 0, 0, 0, 64'h30C);
        expect_out("R4 canonical low", 0, 0, 1);
    endtask

    task automatic t_legacy();
        issue(2'd0, NONCAN_A, 0, 0, 0, 0, 64'h400);
        expect_out("R5 canon skipped", 0, 0, 1);
        issue(2'd1, NONCAN_A | 64'h4, 0, 0, 0, 0, 64'h404);
        expect_out("R5 align still checked", 1, 3, 0);
        issue(2'd3, NONCAN_A, 0, 32'h8000_0000, 0, 0, 64'h408);
        expect_out("R5 rsvd still checked", 1, 1, 0);
    endtask

    task automatic t_priority();
        issue(2'd3, NONCAN_A, 1, 32'h0002_0000, 0, 0, 64'h500);
        expect_out("R6 rsvd over noncanon", 1, 1, 0);
        check(csr_o == 32'h0000_1234, "R6 csr kept", csr_o, 32'h0000_1234);
        issue(2'd1, NONCAN_B | 64'h1, 1, 0, 0, 0, 64'h504);
        expect_out("R6 noncanon over misalign", 1, 2, 0);
        issue(2'd3, NONCAN_A, 1, 32'h0000_0042, 0, 0, 64'h508);
        expect_out("R6 csr noncanon only", 1, 2, 0);
        check(csr_o == 32'h0000_1234, "R6 csr kept on noncanon", csr_o, 32'h0000_1234);
    endtask

    task automatic t_errcode();
        issue(2'd0, NONCAN_A, 1, 0, 1, 16'h002B, 64'h600);
        check(err_o == 16'h002B, "R7 selector in err", err_o, 16'h002B);
        issue(2'd1, 64'h7, 1, 0, 0, 16'h0077, 64'h604);
        check(err_o == 16'h0000, "R7 no descriptor err zero", err_o, 0);
        check(fault_ip_o == 64'h604, "R9 saved ip second", fault_ip_o, 64'h604);
        issue(2'd0, CANON_LO, 1, 0, 1, 16'h0033, 64'h608);
        check(err_o == 16'h0000, "R7 no fault err zero", err_o, 0);
        check(fault_ip_o == 64'h0, "R9 no fault ip zero", fault_ip_o, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        op_i = 2'd3; wdata_i = 32'h0000_0099; addr_i = NONCAN_A;
        @(posedge clk);
        #1;
        check(!fault_o && !commit_o, "R11 idle quiet", {fault_o, commit_o}, 0);
        check(csr_o == 32'h0000_1234, "R11 csr stable", csr_o, 32'h0000_1234);
        idle_inputs();
        issue(2'd1, 64'h40, 1, 0, 0, 0, 64'h700);
        expect_out("R8 commit one cycle", 0, 0, 1);
        @(posedge clk);
        #1;
        check(commit_o == 0, "R8 commit drops", commit_o, 0);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 0;
        t_csr_ok();
        t_csr_rsvd();
        t_align();
        t_canon();
        t_legacy();
        t_priority();
        t_errcode();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule